// File: doc/BRIEF.md
# Burst-Sequencing AHB Bus Master

This block puts an AHB bus master behind a plain memory-like request port. The user side pulses a start strobe together with a transfer kind, an access size, a first address and a direction. The master captures them, raises its bus request and waits for the arbiter's grant. It then issues every beat itself: it works out the next address, drives the transfer code, and moves write data from the user port onto the write bus. Read data coming back from the slave is handed to the user port.

Bursts have a fixed, parameterised beat count. A transfer can be a single access, an incrementing burst, a wrapping burst, or a "fixed" burst that hits the same address on every beat. Slave wait states stretch the data phase and hold the pending address phase. If the arbiter withdraws the grant part-way through, the master asks for the bus again and rebuilds the rest of the burst. A one-cycle completion pulse marks the end of each transfer.

Top module: `ahb_req_master`

## Requirements
- R1: While reset is held, and right after it, HTRANS is IDLE (00), the bus request, `xfer_done`, `xfer_busy` and `rsp_rvalid` are all low.
- R2: `req_kind` codes are 0 single (1 beat), 1 incrementing, 2 fixed and 3 wrapping. Each burst kind runs BEATS beats (4 by default). While an address phase is driven, HBURST shows 0 (SINGLE) for single and fixed transfers, 3 (INCR4) for incrementing and 2 (WRAP4) for wrapping. It shows 1 (INCR) once the burst has been rebuilt after a grant loss. HWRITE matches the captured direction.
- R3: `req_size` 0, 1 and 2 select byte, half-word and word, shown as the same value on HSIZE. Code 3 is treated as word. Incrementing bursts add 1, 2 or 4 to the address on each beat.
- R4: Wrapping bursts stay inside the aligned block of BEATS × access-bytes that holds the first address, and wrap back to the block's start.
- R5: A fixed burst issues every beat at the first address, and every one of its beats is NONSEQ.
- R6: HTRANS is NONSEQ (10) on the first beat of a transfer and SEQ (11) on incrementing or wrapping beats that directly follow an accepted beat. It is IDLE whenever there is nothing to issue.
- R7: An address phase is accepted only on a clock edge with HREADY high. While HREADY is low, the address and control being driven stay unchanged.
- R8: A non-IDLE transfer is driven only while the master owns the bus, meaning HGRANT was high at the last clock edge with HREADY high.
- R9: After the grant is lost mid-burst, the master resumes at the next beat's address with a NONSEQ beat.
- R10: The bus request rises the cycle after an accepted start. It stays high until the last beat's address phase is accepted, and it is high whenever a transfer is driven.
- R11: `req_wnext` is high exactly in the cycle a write beat's address phase is accepted. The `req_wdata` present then appears on HWDATA for that beat's whole data phase.
- R12: One cycle after a read data phase completes with HREADY high, `rsp_rvalid` pulses with that beat's HRDATA on `rsp_rdata`.
- R13: `xfer_done` pulses for one cycle, one cycle after the last data phase completes. `xfer_busy` is high from the cycle after start up to that pulse.
- R14: A start strobe seen while the master is busy is ignored. The running transfer keeps its addresses, kind and beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| req_start | input | 1 | Start strobe, taken when idle |
| req_kind | input | 2 | Transfer kind: 0 single, 1 incr, 2 fixed, 3 wrap |
| req_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| req_addr | input | AW | First beat address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data for the next write beat |
| req_wnext | output | 1 | Current write beat taken; present the next one |
| rsp_rdata | output | DW | Returned read data |
| rsp_rvalid | output | 1 | Read data valid pulse |
| xfer_done | output | 1 | Transfer complete pulse |
| xfer_busy | output | 1 | Transfer in progress |
| hbusreq | output | 1 | Bus request to the arbiter |
| hgrant | input | 1 | Grant from the arbiter |
| htrans | output | 2 | Transfer code |
| haddr | output | AW | Address |
| hwrite | output | 1 | Direction |
| hsize | output | 3 | Access size |
| hburst | output | 3 | Burst code |
| hwdata | output | DW | Write data |
| hready | input | 1 | Slave ready |
| hrdata | input | DW | Read data |

## Verification
Because the bus is pipelined, a beat's address phase is accepted on the same edge that completes the previous beat's data phase. A slave wait state stalls both at once. The stimulus table runs every kind and size under several HREADY masks, so stalls land on overlapped address and data phases. Each cycle is judged against a bench model of the expected address list, HTRANS code, HWDATA index and read-return slot. In other rows, the grant is withdrawn on the same cycle that a beat is accepted. The bench then expects that beat's data to finish normally, the next address phase to wait until ownership returns, and the burst to continue as NONSEQ with INCR coding.

// File: rtl/ahbm_pkg.sv
`timescale 1ns/1ps
package ahbm_pkg;

   typedef enum logic [1:0] {
      XK_SINGLE = 2'd0,
      XK_INCR   = 2'd1,
      XK_FIXED  = 2'd2,
      XK_WRAP   = 2'd3
   } xkind_e;

   localparam logic [1:0] HT_IDLE = 2'b00;
   localparam logic [1:0] HT_NSEQ = 2'b10;
   localparam logic [1:0] HT_SEQ  = 2'b11;

   localparam logic [2:0] HB_SINGLE = 3'd0;
   localparam logic [2:0] HB_INCR   = 3'd1;

   // fixed-length incrementing burst code for a beat count
   function automatic logic [2:0] incr_code(input int beats);
      if (beats == 16)     return 3'd7;
      else if (beats == 8) return 3'd5;
      else                 return 3'd3;
   endfunction

   // fixed-length wrapping burst code for a beat count
   function automatic logic [2:0] wrap_code(input int beats);
      if (beats == 16)     return 3'd6;
      else if (beats == 8) return 3'd4;
      else                 return 3'd2;
   endfunction

   // size code 3 is out of range for the port; fold it onto word
   function automatic logic [1:0] clamp_size(input logic [1:0] s);
      return (s == 2'd3) ? 2'd2 : s;
   endfunction

endpackage

// File: rtl/ahbm_step.sv
`timescale 1ns/1ps
module ahbm_step
   import ahbm_pkg::*;
#(
   parameter int AW    = 32,
   parameter int BEATS = 4
) (
   input  xkind_e          kind,
   input  logic [1:0]      size,
   input  logic [AW-1:0]   cur,
   output logic [AW-1:0]   nxt
);
   localparam int LB = $clog2(BEATS);

   if ((1 << LB) != BEATS) begin : g_bad_pow2
      $error("ahbm_step: BEATS must be a power of two");
   end

   logic [AW-1:0] stride;
   logic [AW-1:0] span;
   logic [AW-1:0] sum;

   assign stride = AW'(1) << size;
   // low-bit mask of the wrap block (BEATS * bytes per beat)
   assign span   = (stride << LB) - AW'(1);
   assign sum    = cur + stride;

   always_comb begin
      unique case (kind)
         XK_FIXED: nxt = cur;
         XK_WRAP:  nxt = (cur & ~span) | (sum & span);
         default:  nxt = sum;
      endcase
   end

endmodule

// File: rtl/ahbm_issue.sv
`timescale 1ns/1ps
module ahbm_issue
   import ahbm_pkg::*;
#(
   parameter int AW    = 32,
   parameter int BEATS = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  xkind_e          kind_i,
   input  logic [1:0]      size_i,
   input  logic [AW-1:0]   addr_i,
   input  logic            write_i,
   input  logic            hgrant,
   input  logic            hready,
   input  logic            last_done,
   output logic [1:0]      htrans,
   output logic [AW-1:0]   haddr,
   output logic            hwrite,
   output logic [2:0]      hsize,
   output logic [2:0]      hburst,
   output logic            hbusreq,
   output logic            accept,
   output logic            acc_last,
   output logic            busy,
   output logic            write_q
);
   localparam int             CW       = $clog2(BEATS + 1);
   localparam logic [CW-1:0]  FULL     = CW'(BEATS);
   localparam logic [CW-1:0]  ONE      = CW'(1);
   localparam logic [2:0]     INC_CODE = incr_code(BEATS);
   localparam logic [2:0]     WRP_CODE = wrap_code(BEATS);

   logic            run_q;
   logic            own_q;
   logic            prev_q;
   logic            req_q;
   logic            res_q;
   xkind_e          kind_q;
   logic [1:0]      size_q;
   logic [AW-1:0]   addr_q;
   logic [CW-1:0]   issued_q;

   logic [CW-1:0]   nbeats;
   logic            want;
   logic            issuing;
   logic            seq_ok;
   logic [AW-1:0]   addr_nx;

   ahbm_step #(.AW(AW), .BEATS(BEATS)) u_step (
      .kind (kind_q),
      .size (size_q),
      .cur  (addr_q),
      .nxt  (addr_nx)
   );

   assign nbeats   = (kind_q == XK_SINGLE) ? ONE : FULL;
   assign want     = run_q && (issued_q != nbeats);
   assign issuing  = own_q && want;
   assign seq_ok   = prev_q && ((kind_q == XK_INCR) || (kind_q == XK_WRAP));
   assign accept   = issuing && hready;
   assign acc_last = accept && (issued_q == (nbeats - ONE));

   assign htrans  = !issuing ? HT_IDLE : (seq_ok ? HT_SEQ : HT_NSEQ);
   assign haddr   = issuing ? addr_q : '0;
   assign hwrite  = issuing && write_q;
   assign hsize   = issuing ? {1'b0, size_q} : 3'd0;
   assign hbusreq = req_q;
   assign busy    = run_q;

   always_comb begin
      hburst = HB_SINGLE;
      if (issuing) begin
         unique case (kind_q)
            XK_INCR: hburst = res_q ? HB_INCR : INC_CODE;
            XK_WRAP: hburst = res_q ? HB_INCR : WRP_CODE;
            default: hburst = HB_SINGLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         own_q    <= 1'b0;
         prev_q   <= 1'b0;
         req_q    <= 1'b0;
         res_q    <= 1'b0;
         kind_q   <= XK_SINGLE;
         size_q   <= 2'd0;
         addr_q   <= '0;
         issued_q <= '0;
         write_q  <= 1'b0;
      end else begin
         if (hready) begin
            own_q  <= hgrant;
            prev_q <= accept;
         end
         if (!run_q) begin
            if (start) begin
               run_q    <= 1'b1;
               kind_q   <= kind_i;
               size_q   <= clamp_size(size_i);
               addr_q   <= addr_i;
               write_q  <= write_i;
               issued_q <= '0;
               req_q    <= 1'b1;
               res_q    <= 1'b0;
            end
         end else begin
            if (accept) begin
               issued_q <= issued_q + ONE;
               addr_q   <= addr_nx;
            end
            if (acc_last) req_q <= 1'b0;
            // burst chain broken by lost ownership
            if (hready && !accept && want && prev_q) res_q <= 1'b1;
            if (last_done) run_q <= 1'b0;
         end
      end
   end

   a_r7_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (htrans != HT_IDLE && !hready) |=> (htrans == $past(htrans) && haddr == $past(haddr)));

   a_r10_req_covers: assert property (@(posedge clk) disable iff (!rst_n)
      (htrans != HT_IDLE) |-> hbusreq);

   a_r14_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && start) |=> (write_q == $past(write_q) && kind_q == $past(kind_q)));

endmodule

// File: rtl/ahbm_dphase.sv
`timescale 1ns/1ps
module ahbm_dphase #(
   parameter int DW     = 32,
   parameter bit RD_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            accept,
   input  logic            acc_last,
   input  logic            write_q,
   input  logic [DW-1:0]   wdata,
   input  logic            hready,
   input  logic [DW-1:0]   hrdata,
   output logic [DW-1:0]   hwdata,
   output logic            rvalid,
   output logic [DW-1:0]   rdata,
   output logic            done,
   output logic            last_done
);
   logic            dv_q;
   logic            dl_q;
   logic            dw_q;
   logic [DW-1:0]   wd_q;
   logic            done_q;
   logic            complete;

   assign complete  = dv_q && hready;
   assign last_done = complete && dl_q;
   assign hwdata    = wd_q;
   assign done      = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dv_q   <= 1'b0;
         dl_q   <= 1'b0;
         dw_q   <= 1'b0;
         wd_q   <= '0;
         done_q <= 1'b0;
      end else begin
         if (hready) begin
            dv_q <= accept;
            dl_q <= acc_last;
            dw_q <= write_q;
         end
         if (accept && write_q) wd_q <= wdata;
         done_q <= last_done;
      end
   end

   if (RD_REG) begin : g_rreg
      logic            rv_q;
      logic [DW-1:0]   rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rv_q <= 1'b0;
            rd_q <= '0;
         end else begin
            rv_q <= complete && !dw_q;
            if (complete && !dw_q) rd_q <= hrdata;
         end
      end
      assign rvalid = rv_q;
      assign rdata  = rd_q;
   end else begin : g_rcomb
      assign rvalid = complete && !dw_q;
      assign rdata  = hrdata;
   end

   a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r11_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dv_q && dw_q && !hready) |=> $stable(hwdata));

endmodule

// File: rtl/ahb_req_master.sv
`timescale 1ns/1ps
module ahb_req_master
   import ahbm_pkg::*;
#(
   parameter int AW     = 32,
   parameter int DW     = 32,
   parameter int BEATS  = 4,
   parameter bit RD_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_start,
   input  logic [1:0]      req_kind,
   input  logic [1:0]      req_size,
   input  logic [AW-1:0]   req_addr,
   input  logic            req_write,
   input  logic [DW-1:0]   req_wdata,
   output logic            req_wnext,
   output logic [DW-1:0]   rsp_rdata,
   output logic            rsp_rvalid,
   output logic            xfer_done,
   output logic            xfer_busy,
   output logic            hbusreq,
   input  logic            hgrant,
   output logic [1:0]      htrans,
   output logic [AW-1:0]   haddr,
   output logic            hwrite,
   output logic [2:0]      hsize,
   output logic [2:0]      hburst,
   output logic [DW-1:0]   hwdata,
   input  logic            hready,
   input  logic [DW-1:0]   hrdata
);
   if (!(BEATS == 4 || BEATS == 8 || BEATS == 16)) begin : g_bad_beats
      $error("ahb_req_master: BEATS must be 4, 8 or 16");
   end
   if (DW < 32) begin : g_bad_dw
      $error("ahb_req_master: DW must hold a word");
   end
   if (AW < 8) begin : g_bad_aw
      $error("ahb_req_master: AW too narrow for a wrap block");
   end

   logic accept;
   logic acc_last;
   logic last_done;
   logic write_q;

   ahbm_issue #(.AW(AW), .BEATS(BEATS)) u_issue (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (req_start),
      .kind_i    (xkind_e'(req_kind)),
      .size_i    (req_size),
      .addr_i    (req_addr),
      .write_i   (req_write),
      .hgrant    (hgrant),
      .hready    (hready),
      .last_done (last_done),
      .htrans    (htrans),
      .haddr     (haddr),
      .hwrite    (hwrite),
      .hsize     (hsize),
      .hburst    (hburst),
      .hbusreq   (hbusreq),
      .accept    (accept),
      .acc_last  (acc_last),
      .busy      (xfer_busy),
      .write_q   (write_q)
   );

   ahbm_dphase #(.DW(DW), .RD_REG(RD_REG)) u_dphase (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .acc_last  (acc_last),
      .write_q   (write_q),
      .wdata     (req_wdata),
      .hready    (hready),
      .hrdata    (hrdata),
      .hwdata    (hwdata),
      .rvalid    (rsp_rvalid),
      .rdata     (rsp_rdata),
      .done      (xfer_done),
      .last_done (last_done)
   );

   assign req_wnext = accept && write_q;

endmodule

// File: tb/sim_ahb_req_master.sv
`timescale 1ns/1ps
module sim_ahb_req_master;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int BEATS = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          req_start = 0;
   logic [1:0]    req_kind = 0;
   logic [1:0]    req_size = 0;
   logic [AW-1:0] req_addr = 0;
   logic          req_write = 0;
   logic [DW-1:0] req_wdata = 0;
   logic          req_wnext;
   logic [DW-1:0] rsp_rdata;
   logic          rsp_rvalid, xfer_done, xfer_busy, hbusreq;
   logic          hgrant = 1;
   logic [1:0]    htrans;
   logic [AW-1:0] haddr;
   logic          hwrite;
   logic [2:0]    hsize, hburst;
   logic [DW-1:0] hwdata;
   logic          hready = 1;
   logic [DW-1:0] hrdata = 0;

   ahb_req_master #(.AW(AW), .DW(DW), .BEATS(BEATS)) u0 (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_kind(req_kind),
      .req_size(req_size), .req_addr(req_addr), .req_write(req_write),
      .req_wdata(req_wdata), .req_wnext(req_wnext), .rsp_rdata(rsp_rdata),
      .rsp_rvalid(rsp_rvalid), .xfer_done(xfer_done), .xfer_busy(xfer_busy),
      .hbusreq(hbusreq), .hgrant(hgrant), .htrans(htrans), .haddr(haddr),
      .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hwdata(hwdata),
      .hready(hready), .hrdata(hrdata)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   function automatic logic [31:0] rd_fn(input logic [31:0] a);
      return {a[15:0], ~a[15:0]};
   endfunction

   // next beat address from the requirement formulas (R3, R4, R5)
   function automatic logic [31:0] bnext(input int k, input int s, input logic [31:0] a);
      logic [31:0] st, blk, base;
      st = 32'(1 << s);
      blk = st * 32'(BEATS);
      base = a - (a % blk);
      case (k)
         2: return a;
         3: return base + ((a - base + st) % blk);
         default: return a + st;
      endcase
   endfunction

   // row: kind[47:46] size[45:44] write[43] drop[42:40] ready_mask[39:32] addr[31:0]
   localparam int NROW = 13;
   localparam logic [47:0] ROWS [NROW] = '{
      {2'd0, 2'd2, 1'b0, 3'd7, 8'hFF, 32'h0000_1000},
      {2'd0, 2'd0, 1'b1, 3'd7, 8'hFF, 32'h0000_1003},
      {2'd1, 2'd2, 1'b0, 3'd7, 8'hFF, 32'h0000_2000},
      {2'd1, 2'd1, 1'b1, 3'd7, 8'hB6, 32'h0000_2002},
      {2'd1, 2'd0, 1'b0, 3'd7, 8'hFF, 32'h0000_20FE},
      {2'd3, 2'd2, 1'b0, 3'd7, 8'hFF, 32'h0000_300C},
      {2'd3, 2'd1, 1'b1, 3'd7, 8'hDB, 32'h0000_3006},
      {2'd3, 2'd0, 1'b0, 3'd7, 8'hFF, 32'h0000_3002},
      {2'd2, 2'd2, 1'b1, 3'd7, 8'h6D, 32'h0000_4008},
      {2'd1, 2'd2, 1'b0, 3'd2, 8'hFF, 32'h0000_5000},
      {2'd3, 2'd2, 1'b1, 3'd1, 8'hEE, 32'h0000_3008},
      {2'd2, 2'd1, 1'b0, 3'd3, 8'hFF, 32'h0000_4004},
      {2'd1, 2'd3, 1'b0, 3'd7, 8'hFF, 32'h0000_6000}
   };

   // bench model state
   bit          own = 0, prev = 0, res = 0, in_xfer = 0, fin = 0;
   bit          dp_pend = 0, rv_pend = 0, done_pend = 0, dropped = 0, waited = 0;
   bit          start_now = 0;
   int          acc_cnt = 0, nb = 1, kind = 0, esz = 0, dp_idx = 0, wcnt = 0;
   int          goff = 0, drop = 7, t = 0, extra_t = -1;
   bit          wr = 0;
   logic [7:0]  rdy = 8'hFF;
   logic [31:0] rv_data = 0;
   logic [31:0] exp_a [16];

   task automatic cyc();
      bit wantb, acc, rv_n, done_n, endx;
      logic [1:0] etr;
      logic [2:0] eb;
      string tg;
      @(negedge clk);
      req_start = start_now;
      if (in_xfer && t == extra_t) begin
         req_start = 1'b1;
         req_addr  = 32'hDEAD_0000;
         req_kind  = 2'd0;
      end
      if (in_xfer && drop != 7 && !dropped && acc_cnt == drop) begin
         goff = 2;
         dropped = 1;
      end
      hgrant = (goff == 0);
      if (goff > 0) goff--;
      hready = in_xfer ? rdy[t % 8] : 1'b1;
      req_wdata = 32'hC0DE_0000 + 32'(wcnt);
      hrdata = dp_pend ? rd_fn(exp_a[dp_idx]) : 32'h0;
      #5;
      wantb = in_xfer && (acc_cnt < nb);
      etr = (own && wantb) ? ((prev && (kind == 1 || kind == 3)) ? 2'b11 : 2'b10) : 2'b00;
      if (wantb && !own) tg = "R8";
      else if (res && etr == 2'b10 && acc_cnt > 0) tg = "R9";
      else if (kind == 2 && etr != 0) tg = "R5";
      else tg = "R6";
      chk(htrans == etr, tg, 32'(htrans), 32'(etr));
      chk(hbusreq == wantb, "R10", 32'(hbusreq), 32'(wantb));
      chk(xfer_busy == (in_xfer && !fin), "R13", 32'(xfer_busy), 32'(in_xfer && !fin));
      if (etr != 0) begin
         if (waited) tg = "R7";
         else if (res) tg = "R9";
         else if (kind == 3) tg = "R4";
         else if (kind == 2) tg = "R5";
         else tg = "R3";
         chk(haddr == exp_a[acc_cnt], tg, haddr, exp_a[acc_cnt]);
         chk(hsize == 3'(esz), "R3", 32'(hsize), 32'(esz));
         chk(hwrite == wr, "R2", 32'(hwrite), 32'(wr));
         if (res && (kind == 1 || kind == 3)) eb = 3'd1;
         else if (kind == 1) eb = 3'd3;
         else if (kind == 3) eb = 3'd2;
         else eb = 3'd0;
         chk(hburst == eb, "R2", 32'(hburst), 32'(eb));
      end
      acc = (etr != 0) && hready;
      chk(req_wnext == (acc && wr), "R11", 32'(req_wnext), 32'(acc && wr));
      rv_n = 0;
      done_n = 0;
      if (dp_pend && hready) begin
         if (wr) chk(hwdata == 32'hC0DE_0000 + 32'(dp_idx), "R11", hwdata, 32'hC0DE_0000 + 32'(dp_idx));
         else begin
            rv_n = 1;
         end
         if (dp_idx == nb - 1) done_n = 1;
      end
      chk(rsp_rvalid == rv_pend, "R12", 32'(rsp_rvalid), 32'(rv_pend));
      if (rv_pend) chk(rsp_rdata == rv_data, "R12", rsp_rdata, rv_data);
      chk(xfer_done == done_pend, "R13", 32'(xfer_done), 32'(done_pend));
      endx = done_pend;
      if (rv_n) rv_data = rd_fn(exp_a[dp_idx]);
      waited = (etr != 0) && !hready;
      if (hready) begin
         if (prev && !acc && wantb) res = 1;
         prev = acc;
         own = hgrant;
         dp_pend = acc;
         dp_idx = acc_cnt;
      end
      if (acc) begin
         acc_cnt++;
         if (wr) wcnt++;
      end
      rv_pend = rv_n;
      done_pend = done_n;
      if (done_n) fin = 1;
      if (endx) in_xfer = 0;
      start_now = 0;
      t++;
   endtask

   task automatic run_row(input logic [47:0] r, input int xt);
      int guard;
      kind = int'(r[47:46]);
      esz = (r[45:44] == 2'd3) ? 2 : int'(r[45:44]);
      wr = r[43];
      drop = int'(r[42:40]);
      rdy = r[39:32];
      nb = (kind == 0) ? 1 : BEATS;
      exp_a[0] = r[31:0];
      for (int i = 1; i < nb; i++) exp_a[i] = bnext(kind, esz, exp_a[i-1]);
      req_kind = r[47:46];
      req_size = r[45:44];
      req_write = wr;
      req_addr = r[31:0];
      start_now = 1;
      extra_t = xt;
      cyc();
      in_xfer = 1;
      acc_cnt = 0; fin = 0; res = 0; wcnt = 0; dropped = 0; goff = 0; t = 1; waited = 0;
      guard = 0;
      while (in_xfer && guard < 300) begin
         cyc();
         guard++;
      end
      chk(!in_xfer, "R13", 32'(in_xfer), 32'h0);
      chk(acc_cnt == nb, (xt > 0) ? "R14" : "R2", 32'(acc_cnt), 32'(nb));
      in_xfer = 0;
      cyc();
      cyc();
   endtask

   initial begin
      #(3_000_000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1: outputs while in reset
      repeat (3) begin
         @(negedge clk);
         #5;
         chk(htrans == 2'b00, "R1", 32'(htrans), 0);
         chk(hbusreq == 0, "R1", 32'(hbusreq), 0);
         chk(xfer_done == 0 && xfer_busy == 0 && rsp_rvalid == 0, "R1",
             {29'd0, xfer_done, xfer_busy, rsp_rvalid}, 0);
      end
      @(negedge clk);
      rst_n = 1;
      // R1: quiet after reset release, before any start
      cyc();
      cyc();
      for (int i = 0; i < NROW; i++) run_row(ROWS[i], -1);
      // R14: start strobe in mid-burst is ignored
      run_row(ROWS[2], 3);
      run_row(ROWS[6], 2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule